// File: doc/BRIEF.md
# Tick-Driven Real-Time Clock with Register Access

This block keeps wall-clock time as one packed 32-bit word: a day count, hours, minutes and seconds. A divider turns the input clock into a one-per-second tick. Each tick advances the time, counts a stopwatch down toward zero and compares the new time with an alarm word. Four event kinds latch into a sticky status register, and a single interrupt line goes high whenever a latched event is also enabled.

Software reaches the block through a plain register bus. A write is one cycle with `bus_wr_en` high. The block accepts every access at once and never applies back-pressure, so there is no valid/ready pair. Read data is a combinational function of `bus_addr` and is valid in the same cycle. The two low address bits are ignored. Sixteen-bit registers take `bus_wdata[15:0]` and read back zero-extended.

Top module: `rtc_mmio`

## Requirements
- R1: The time word holds seconds in bits 5:0, minutes in 11:6, hours in 16:12 and days in 31:17. On each tick, seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into days. Days wrap from 0x7FFF to 0.
- R2: While bit 0 of the prescaler-enable register (offset 0x14) is 1, a tick occurs every TICKS_PER_SEC cycles. The first tick lands TICKS_PER_SEC cycles after the enabling write. While the bit is 0 the time does not change.
- R3: A write to offset 0x00 loads the whole time word in one cycle. A load wins over a tick in the same cycle.
- R4: Register map and widths:
  - Offsets 0x04 (interrupt enable), 0x0C (stopwatch) and 0x14 (prescaler enable) store 16 bits and read them back zero-extended.
  - Offset 0x10 (alarm) reads back all 32 written bits.
  - Any other offset reads 0.
- R5: Interrupt status (offset 0x08) bit 2 sets on every tick. Bit 3 sets on a tick that takes seconds from 59 to 0.
- R6: Status bit 1 sets when a tick moves the time to a value equal to the alarm word. A time load does not set it.
- R7: On each tick the stopwatch decrements if it is non-zero. Status bit 0 sets on the tick that moves it from 1 to 0. At 0 the stopwatch stays at 0 and raises nothing more.
- R8: Writing 1 to a status bit in 3:0 clears it, and writing 0 leaves it alone. Bit 14 and all bits above 3 read 0 and ignore writes. A new event in the same cycle as a clear keeps the bit set.
- R9: `irq` is high exactly when some status bit in 3:0 is set and the same bit of the interrupt-enable register is set.
- R10: After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Enabled-event interrupt |

## Verification
The hardest cases to reach are rare carries, such as the day count wrapping after 23:59:59, and events that need an exact number of ticks. The bench reaches the carries by loading a time word just below a boundary instead of counting up to it. It gets exact tick counts by writing the prescaler enable, waiting an exact number of cycles, and then clearing the enable on the cycle of the last tick. On top of these directed cases, random loaded times advanced by random tick counts are compared against a bench function that applies the carry rules.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [14:0] day;
    logic [4:0]  hour;
    logic [5:0]  min;
    logic [5:0]  sec;
  } rtc_time_t;

  // word indices (byte offset / 4)
  localparam int IDX_TIME  = 0;
  localparam int IDX_IEN   = 1;
  localparam int IDX_ISTAT = 2;
  localparam int IDX_SWC   = 3;
  localparam int IDX_ALARM = 4;
  localparam int IDX_PREN  = 5;

  localparam int EVT_SW     = 0;
  localparam int EVT_ALARM  = 1;
  localparam int EVT_SEC    = 2;
  localparam int EVT_MIN    = 3;
  localparam int EVT_COUNT  = 4;
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!en || cnt_q == LAST) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && (cnt_q == LAST);

  generate
    if (TICKS_PER_SEC >= 2) begin : g_gap
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t time_q,
  output rtc_time_t time_nxt,
  output logic      min_evt
);
  always_comb begin
    time_nxt = time_q;
    if (time_q.sec >= 6'd59) begin
      time_nxt.sec = '0;
      if (time_q.min >= 6'd59) begin
        time_nxt.min = '0;
        if (time_q.hour >= 5'd23) begin
          time_nxt.hour = '0;
          time_nxt.day  = time_q.day + 15'd1;
        end else begin
          time_nxt.hour = time_q.hour + 5'd1;
        end
      end else begin
        time_nxt.min = time_q.min + 6'd1;
      end
    end else begin
      time_nxt.sec = time_q.sec + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    time_q <= '0;
    else if (load) time_q <= load_val;
    else if (tick) time_q <= time_nxt;
  end

  assign min_evt = tick && !load && (time_q.sec >= 6'd59);

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(time_q));
  // R1
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (time_q.sec <= 6'd59 && time_q.min <= 6'd59));
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int SW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  logic [SW_W-1:0] load_val,
  output logic [SW_W-1:0] cnt_q,
  output logic            zero_evt
);
  localparam logic [SW_W-1:0] ONE = SW_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign zero_evt = tick && !load && (cnt_q == ONE);

  // R7
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/rtc_mmio.sv
module rtc_mmio
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 5,
  parameter int REG16_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   word_idx;
  logic               wr_time, wr_ien, wr_istat, wr_swc, wr_alarm, wr_pren;
  logic [REG16_W-1:0] ien_q, pren_q;
  logic [31:0]        alarm_q;
  logic [EVT_COUNT-1:0] istat_q, evt_set, evt_clr;
  logic               tick, min_evt, sw_zero;
  rtc_time_t          time_q, time_nxt;
  logic [REG16_W-1:0] swc_q;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign wr_time  = bus_wr_en && (int'(word_idx) == IDX_TIME);
  assign wr_ien   = bus_wr_en && (int'(word_idx) == IDX_IEN);
  assign wr_istat = bus_wr_en && (int'(word_idx) == IDX_ISTAT);
  assign wr_swc   = bus_wr_en && (int'(word_idx) == IDX_SWC);
  assign wr_alarm = bus_wr_en && (int'(word_idx) == IDX_ALARM);
  assign wr_pren  = bus_wr_en && (int'(word_idx) == IDX_PREN);

  rtc_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_n), .en(pren_q[0]), .tick(tick)
  );

  rtc_timekeeper u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_time),
    .load_val(rtc_time_t'(bus_wdata)), .time_q(time_q),
    .time_nxt(time_nxt), .min_evt(min_evt)
  );

  rtc_stopwatch #(.SW_W(REG16_W)) u_sw (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_swc),
    .load_val(bus_wdata[REG16_W-1:0]), .cnt_q(swc_q), .zero_evt(sw_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q   <= '0;
      pren_q  <= '0;
      alarm_q <= '0;
    end else begin
      if (wr_ien)   ien_q   <= bus_wdata[REG16_W-1:0];
      if (wr_pren)  pren_q  <= bus_wdata[REG16_W-1:0];
      if (wr_alarm) alarm_q <= bus_wdata;
    end
  end

  always_comb begin
    evt_set = '0;
    evt_set[EVT_SW]    = sw_zero;
    evt_set[EVT_ALARM] = tick && !wr_time && (time_nxt == rtc_time_t'(alarm_q));
    evt_set[EVT_SEC]   = tick;
    evt_set[EVT_MIN]   = min_evt;
  end

  assign evt_clr = wr_istat ? bus_wdata[EVT_COUNT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) istat_q <= '0;
    else        istat_q <= (istat_q & ~evt_clr) | evt_set;
  end

  assign irq = |(istat_q & ien_q[EVT_COUNT-1:0]);

  always_comb begin
    case (int'(word_idx))
      IDX_TIME:  bus_rdata = time_q;
      IDX_IEN:   bus_rdata = 32'(ien_q);
      IDX_ISTAT: bus_rdata = 32'(istat_q);
      IDX_SWC:   bus_rdata = 32'(swc_q);
      IDX_ALARM: bus_rdata = alarm_q;
      IDX_PREN:  bus_rdata = 32'(pren_q);
      default:   bus_rdata = '0;
    endcase
  end

  // R8
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((istat_q & $past(istat_q & ~evt_clr)) == $past(istat_q & ~evt_clr)));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q[EVT_COUNT-1:0] == '0) |-> !irq);
  // R6
  alarm_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(wr_istat)) |-> (istat_q[EVT_ALARM] == $past(istat_q[EVT_ALARM])));
endmodule

// File: tb/rtc_mmio_tb.sv
`timescale 1ns/1ps
module rtc_mmio_tb;
  localparam int TPS = 4;
  localparam logic [4:0] A_TIME = 5'h00, A_IEN = 5'h04, A_IST = 5'h08,
                         A_SWC = 5'h0C, A_ALM = 5'h10, A_PREN = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_mmio #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] pack(int d, int h, int m, int s);
    return {15'(d), 5'(h), 6'(m), 6'(s)};
  endfunction

  function automatic logic [31:0] advance(logic [31:0] t, int n);
    int s, m, h, d;
    s = int'(t[5:0]); m = int'(t[11:6]); h = int'(t[16:12]); d = int'(t[31:17]);
    for (int i = 0; i < n; i++) begin
      s++;
      if (s == 60) begin
        s = 0; m++;
        if (m == 60) begin
          m = 0; h++;
          if (h == 24) begin h = 0; d = (d + 1) % 32768; end
        end
      end
    end
    return pack(d, h, m, s);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // exactly k ticks, then prescaler off on the cycle of the last tick
  task automatic run_ticks(int k);
    wr(A_PREN, 32'h1);
    repeat (k * TPS - 2) @(negedge clk);
    wr(A_PREN, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, t0, exp_t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    foreach (v[i]) ;
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v);
      check("R10", "reset register", v, 32'h0);
    end
    check("R10", "reset irq", 32'(irq), 32'h0);

    // R4 widths and readback
    wr(A_IEN, 32'hABCD_1234);  rd(A_IEN, v);  check("R4", "ien 16-bit", v, 32'h0000_1234);
    wr(A_SWC, 32'h5555_0007);  rd(A_SWC, v);  check("R4", "swc 16-bit", v, 32'h0000_0007);
    wr(A_ALM, 32'hDEAD_BEEF);  rd(A_ALM, v);  check("R4", "alarm 32-bit", v, 32'hDEAD_BEEF);
    wr(5'h18, 32'hFFFF_FFFF);  rd(5'h18, v);  check("R4", "unmapped", v, 32'h0);
    wr(A_IEN, 32'h0); wr(A_SWC, 32'h0);

    // R3 load, R2 hold while disabled
    t0 = pack(5, 10, 20, 30);
    wr(A_TIME, t0); rd(A_TIME, v); check("R3", "time load", v, t0);
    repeat (3 * TPS) @(negedge clk);
    rd(A_TIME, v); check("R2", "hold when disabled", v, t0);

    // R2 first tick timing
    wr(A_PREN, 32'h1);
    repeat (TPS - 1) @(negedge clk);
    rd(A_TIME, v); check("R2", "before first tick", v, t0);
    @(negedge clk);
    rd(A_TIME, v); check("R2", "first tick", v, advance(t0, 1));
    wr(A_PREN, 32'h0);
    rd(A_TIME, v); t0 = v;
    repeat (2 * TPS) @(negedge clk);
    rd(A_TIME, v); check("R2", "hold after disable", v, t0);

    // R5 minute event and R8 clear
    wr(A_IST, 32'hF);
    wr(A_TIME, pack(0, 0, 0, 58));
    rd(A_IST, v); check("R6", "load sets no event", v, 32'h0);
    run_ticks(1);
    rd(A_IST, v); check("R5", "second event only", v, 32'h4);
    run_ticks(1);
    rd(A_TIME, v); check("R1", "sec carry", v, pack(0, 0, 1, 0));
    rd(A_IST, v); check("R5", "minute event", v, 32'hC);
    wr(A_IST, 32'h0000_4008);
    rd(A_IST, v); check("R8", "partial w1c, bit14 reads 0", v, 32'h4);
    wr(A_IST, 32'h0);
    rd(A_IST, v); check("R8", "write zero keeps", v, 32'h4);

    // R9 irq masking
    check("R9", "irq masked", 32'(irq), 32'h0);
    wr(A_IEN, 32'h8); check("R9", "irq other bit", 32'(irq), 32'h0);
    wr(A_IEN, 32'h4); check("R9", "irq enabled", 32'(irq), 32'h1);
    wr(A_IST, 32'h4); check("R9", "irq after clear", 32'(irq), 32'h0);
    wr(A_IEN, 32'h0);

    // R1 day wrap and hour carry
    wr(A_TIME, pack(32767, 23, 59, 59)); run_ticks(1);
    rd(A_TIME, v); check("R1", "day wrap", v, 32'h0);
    wr(A_TIME, pack(3, 22, 59, 59)); run_ticks(1);
    rd(A_TIME, v); check("R1", "hour carry", v, pack(3, 23, 0, 0));

    // R6 alarm
    t0 = pack(9, 4, 7, 10);
    wr(A_TIME, t0); wr(A_ALM, advance(t0, 2)); wr(A_IST, 32'hF);
    run_ticks(1);
    rd(A_IST, v); check("R6", "no alarm yet", v & 32'h2, 32'h0);
    run_ticks(1);
    rd(A_IST, v); check("R6", "alarm match", v & 32'h2, 32'h2);
    wr(A_IEN, 32'h2); check("R9", "irq on alarm", 32'(irq), 32'h1);
    wr(A_IEN, 32'h0);
    wr(A_IST, 32'hF); run_ticks(1);
    rd(A_IST, v); check("R6", "alarm passed", v & 32'h2, 32'h0);

    // R7 stopwatch
    wr(A_SWC, 32'h3); run_ticks(2);
    rd(A_SWC, v); check("R7", "sw after 2", v, 32'h1);
    rd(A_IST, v); check("R7", "no zero event yet", v & 32'h1, 32'h0);
    run_ticks(1);
    rd(A_SWC, v); check("R7", "sw zero", v, 32'h0);
    rd(A_IST, v); check("R7", "zero event", v & 32'h1, 32'h1);
    wr(A_IST, 32'hF); run_ticks(2);
    rd(A_SWC, v); check("R7", "sw stays zero", v, 32'h0);
    rd(A_IST, v); check("R7", "no repeat event", v & 32'h1, 32'h0);

    // R1/R2 random loaded times advanced by random tick counts
    for (int it = 0; it < 25; it++) begin
      int k;
      t0 = pack($urandom % 32768, $urandom % 24, $urandom % 60, $urandom % 60);
      k = 1 + int'($urandom % 70);
      wr(A_TIME, t0);
      run_ticks(k);
      exp_t = advance(t0, k);
      rd(A_TIME, v); check("R1", "random advance", v, exp_t);
    end

    finish_run();
  end
endmodule